// File: doc/BRIEF.md
# Memory Array Supply Switch Sequencer

This block moves the supply of on-chip memory arrays between two rails: a variable rail shared with the CPU cluster, and a fixed memory rail. A single-cycle request names the target rail. The block then issues a timed series of register-style writes on a shared 8-bit data bus, using separate strobes to select the target. The targets are six power-manager event lines, a clock-source mux and two cluster PLL controls. It writes a mode command to the array power mux and polls the mux status until the switch completes or the poll limit is reached.

On older silicon the rail change must be wrapped in clock and event handling. The events are cleared and the clocks are moved to a safe source before the mode write. Afterwards the events are set again and the clocks are restored. The order of those two trailing steps depends on the direction of the switch. A revision input, sampled when a request is accepted, selects between this wrapped sequence and a bare mode write plus poll. All delays come from the clock period parameter and are rounded up to whole cycles.

Top module: `mem_rail_sequencer`

## Requirements
- R1: After reset, `rail_sel` is 0 (cluster rail), and `busy`, `timeout_err` and all write strobes are 0.
- R2: A request is accepted only while `busy` is 0. `busy` then stays high until the sequence ends. A request made while `busy` is high has no effect: no second mode write occurs, and the target of the running switch is kept.
- R3: If `hw_rev` < 0x10020000 at acceptance, the sequence begins with all six `evt_we` bits asserted together with data 0x00. The mux write with 0x13 follows 250 cycles later. PLL0 and then PLL1 are written with 0xB0, each 25 cycles after the previous write.
- R4: The mode write (`mode_we`) carries 0x00 when the target is the memory rail (`req_rail`=1) and 0x10 when the target is the cluster rail (`req_rail`=0).
- R5: Completion is detected when `status_in[3:0]` equals 0x0 (memory target) or 0x3 (cluster target); bits above 3 are ignored. Status is sampled first in the cycle after the mode write, then every 125 cycles, for at most 10 samples.
- R6: For a memory-rail target on older revisions, the trailing steps are: mux write 0x03, then PLL0 write 0x30 and PLL1 write 0x30, 25 cycles apart. After these, all six events are written with 0x01.
- R7: For a cluster-rail target on older revisions, the six events are written with 0x01 first. The restore writes (0x03 to the mux, then 0x30 to PLL0 and to PLL1) follow.
- R8: If `hw_rev` >= 0x10020000, only the mode write and the poll take place. No event, mux or PLL strobe is asserted.
- R9: `rail_sel` takes the target value in the cycle `busy` falls, and only if completion was seen. After 10 failed samples, `timeout_err` is set, `rail_sel` keeps its old value, and the trailing steps still run.
- R10: `timeout_err` stays set until the next request is accepted, and clears in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle switch request |
| req_rail | input | 1 | Target rail: 0 cluster, 1 memory |
| hw_rev | input | 32 | Hardware revision code |
| status_in | input | 8 | Array mux status |
| wr_data | output | 8 | Data for whichever strobe is active |
| evt_we | output | 6 | Power-manager event write strobes |
| mux_we | output | 1 | Clock-source mux write strobe |
| pll_we | output | 2 | PLL control write strobes (bit 0 = PLL0) |
| mode_we | output | 1 | Array mux mode write strobe |
| rail_sel | output | 1 | Rail currently supplying the arrays |
| busy | output | 1 | Sequence in progress |
| timeout_err | output | 1 | Last switch timed out |

## Verification
A wrong state or counter shows up at the ports as a write strobe that arrives in the wrong order or at the wrong cycle offset. The bench timestamps every strobe and compares the spacing with the cycle counts in the requirements. A mistake in the direction or revision choice therefore shows up at the first trailing write, or at the first write after acceptance. A wrong poll count or wrong status compare shows up as a first trailing write at the wrong cycle, or as a wrong `rail_sel`/`timeout_err` when `busy` falls. That can be up to 1127 cycles after the mode write.

// File: rtl/mem_rail_sequencer.sv
module mem_rail_sequencer #(
  parameter int          CLK_NS     = 8,
  parameter int          GAP_NS     = 200,
  parameter int          WAKE_NS    = 2000,
  parameter int          POLL_NS    = 1000,
  parameter int          POLL_TRIES = 10,
  parameter int          N_EVT      = 6,
  parameter int          STAT_W     = 8,
  parameter logic [31:0] REV_LIMIT  = 32'h1002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rail,
  input  logic [31:0]       hw_rev,
  input  logic [STAT_W-1:0] status_in,
  output logic [7:0]        wr_data,
  output logic [N_EVT-1:0]  evt_we,
  output logic              mux_we,
  output logic [1:0]        pll_we,
  output logic              mode_we,
  output logic              rail_sel,
  output logic              busy,
  output logic              timeout_err
);

  localparam int GAP_CYC  = (GAP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int WAKE_CYC = (WAKE_NS + CLK_NS - 1) / CLK_NS;
  localparam int POLL_CYC = (POLL_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAX_A    = WAKE_CYC > POLL_CYC ? WAKE_CYC : POLL_CYC;
  localparam int MAX_CYC  = MAX_A > GAP_CYC ? MAX_A : GAP_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int TRY_W    = $clog2(POLL_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_EVCLR, S_CSEL, S_PSEL0, S_PSEL1, S_MODE, S_POLL,
    S_RMUX, S_RPLL0, S_RPLL1, S_EVSET
  } st_t;

  st_t              st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic [TRY_W-1:0] tries;
  logic             tgt_q, legacy_q, ok_q;
  logic             first, hit, last_try, step_end;

  assign busy     = (st != S_IDLE);
  assign first    = (cnt == '0);
  assign hit      = tgt_q ? (status_in[3:0] == 4'h0) : (status_in[3:0] == 4'h3);
  assign last_try = (tries == TRY_W'(POLL_TRIES - 1));

  function automatic int hold_of(st_t s);
    case (s)
      S_EVCLR:                       return WAKE_CYC;
      S_CSEL, S_PSEL0, S_RMUX, S_RPLL0: return GAP_CYC;
      default:                       return 1;
    endcase
  endfunction

  assign step_end = (cnt == CNT_W'(hold_of(st) - 1));

  // state after the poll, and after each trailing step, by direction
  always_comb begin
    st_nx = S_IDLE;
    case (st)
      S_EVCLR: st_nx = S_CSEL;
      S_CSEL:  st_nx = S_PSEL0;
      S_PSEL0: st_nx = S_PSEL1;
      S_PSEL1: st_nx = S_MODE;
      S_MODE:  st_nx = S_POLL;
      S_POLL:  st_nx = !legacy_q ? S_IDLE : (tgt_q ? S_RMUX : S_EVSET);
      S_RMUX:  st_nx = S_RPLL0;
      S_RPLL0: st_nx = S_RPLL1;
      S_RPLL1: st_nx = tgt_q ? S_EVSET : S_IDLE;
      S_EVSET: st_nx = tgt_q ? S_IDLE : S_RMUX;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      tries       <= '0;
      tgt_q       <= 1'b0;
      legacy_q    <= 1'b0;
      ok_q        <= 1'b0;
      rail_sel    <= 1'b0;
      timeout_err <= 1'b0;
    end else if (st == S_IDLE) begin
      cnt   <= '0;
      tries <= '0;
      if (req_valid) begin
        tgt_q       <= req_rail;
        legacy_q    <= (hw_rev < REV_LIMIT);
        ok_q        <= 1'b0;
        timeout_err <= 1'b0;
        st          <= (hw_rev < REV_LIMIT) ? S_EVCLR : S_MODE;
      end
    end else if (st == S_POLL) begin
      if (first && (hit || last_try)) begin
        ok_q  <= hit;
        cnt   <= '0;
        st    <= st_nx;
        if (st_nx == S_IDLE) begin
          if (hit) rail_sel <= tgt_q;
          else     timeout_err <= 1'b1;
        end
      end else if (cnt == CNT_W'(POLL_CYC - 1)) begin
        cnt   <= '0;
        tries <= tries + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (step_end) begin
      cnt <= '0;
      st  <= st_nx;
      if (st_nx == S_IDLE) begin
        if (ok_q) rail_sel <= tgt_q;
        else      timeout_err <= 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign evt_we  = {N_EVT{first && (st == S_EVCLR || st == S_EVSET)}};
  assign mux_we  = first && (st == S_CSEL || st == S_RMUX);
  assign pll_we  = {first && (st == S_PSEL1 || st == S_RPLL1),
                    first && (st == S_PSEL0 || st == S_RPLL0)};
  assign mode_we = first && (st == S_MODE);

  always_comb begin
    case (st)
      S_EVCLR:          wr_data = 8'h00;
      S_EVSET:          wr_data = 8'h01;
      S_CSEL:           wr_data = 8'h13;
      S_PSEL0, S_PSEL1: wr_data = 8'hB0;
      S_RMUX:           wr_data = 8'h03;
      S_RPLL0, S_RPLL1: wr_data = 8'h30;
      S_MODE:           wr_data = tgt_q ? 8'h00 : 8'h10;
      default:          wr_data = 8'h00;
    endcase
  end

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (evt_we == '0 && !mux_we && pll_we == 2'b00 && !mode_we));

  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_we, mux_we, |evt_we, pll_we[0], pll_we[1]}));

  a_r3_events_together: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_we) |-> (&evt_we));

  a_r8_new_rev_bare: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !legacy_q) |-> (evt_we == '0 && !mux_we && pll_we == 2'b00));

  a_r9_rail_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rail_sel));

  a_r9_timeout_keeps_rail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $stable(rail_sel));

endmodule

// File: tb/mem_rail_sequencer_tb.sv
module mem_rail_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_rail = 1'b0;
  logic [31:0] hw_rev = 32'h1001_0000;
  logic [7:0]  status_in = 8'h00;
  logic [7:0]  wr_data;
  logic [5:0]  evt_we;
  logic        mux_we, mode_we, rail_sel, busy, timeout_err;
  logic [1:0]  pll_we;

  mem_rail_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rail(req_rail),
    .hw_rev(hw_rev), .status_in(status_in), .wr_data(wr_data),
    .evt_we(evt_we), .mux_we(mux_we), .pll_we(pll_we), .mode_we(mode_we),
    .rail_sel(rail_sel), .busy(busy), .timeout_err(timeout_err)
  );

  always #4 clk = ~clk;

  // kinds: 1 events, 2 mux, 3 pll0, 4 pll1, 5 mode
  int checks = 0, fails = 0;
  int cyc = 0;
  int log_n = 0;
  int log_k[32];
  int log_d[32];
  int log_c[32];
  int t_req;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (evt_we != 6'h00 && evt_we != 6'h3F) chk(0, "R3 partial event strobe", evt_we, 6'h3F);
    if (log_n < 32) begin
      if (evt_we == 6'h3F) begin log_k[log_n] = 1; log_d[log_n] = wr_data; log_c[log_n] = cyc; log_n++; end
      else if (mux_we)     begin log_k[log_n] = 2; log_d[log_n] = wr_data; log_c[log_n] = cyc; log_n++; end
      else if (pll_we[0])  begin log_k[log_n] = 3; log_d[log_n] = wr_data; log_c[log_n] = cyc; log_n++; end
      else if (pll_we[1])  begin log_k[log_n] = 4; log_d[log_n] = wr_data; log_c[log_n] = cyc; log_n++; end
      else if (mode_we)    begin log_k[log_n] = 5; log_d[log_n] = wr_data; log_c[log_n] = cyc; log_n++; end
    end
  end

  task automatic entry(input int i, input int k, input int d, input string tag);
    chk(i < log_n && log_k[i] == k, {tag, " kind"}, (i < log_n) ? log_k[i] : -1, k);
    chk(i < log_n && log_d[i] == d, {tag, " data"}, (i < log_n) ? log_d[i] : -1, d);
  endtask

  task automatic gap(input int i, input int n, input string tag);
    int a;
    a = (i < log_n) ? log_c[i] - log_c[i-1] : -1;
    chk(a == n, tag, a, n);
  endtask

  // start a switch; status becomes 'good' d cycles after the mode write (d<0: never)
  task automatic start(input bit rail, input logic [31:0] rev, input logic [7:0] init_s,
                       input logic [7:0] good, input int d);
    log_n = 0;
    status_in = init_s;
    hw_rev = rev;
    if (d >= 0) fork
      begin
        do @(negedge clk); while (!mode_we);
        repeat (d) @(negedge clk);
        status_in = good;
      end
    join_none
    @(negedge clk);
    t_req = cyc;
    req_rail = rail;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    chk(rail_sel == 1'b0, "R1 rail after reset", rail_sel, 0);
    chk(!busy && !timeout_err, "R1 busy/err after reset", {busy, timeout_err}, 0);
    chk(evt_we == 0 && !mux_we && pll_we == 0 && !mode_we, "R1 strobes after reset",
        {evt_we, mux_we, pll_we, mode_we}, 0);
  endtask

  task automatic t_legacy_mem;
    int m;
    start(1'b1, 32'h1001_0000, 8'h05, 8'h00, 300);
    chk(busy, "R2 busy after accept", busy, 1);
    wait_idle();
    chk(log_n == 9, "R3 R6 write count", log_n, 9);
    entry(0, 1, 8'h00, "R3 event clear");
    chk(log_c[0] == t_req + 1, "R3 first write cycle", log_c[0], t_req + 1);
    entry(1, 2, 8'h13, "R3 mux select");  gap(1, 250, "R3 wake gap");
    entry(2, 3, 8'hB0, "R3 pll0 override"); gap(2, 25, "R3 gap pll0");
    entry(3, 4, 8'hB0, "R3 pll1 override"); gap(3, 25, "R3 gap pll1");
    entry(4, 5, 8'h00, "R4 mode memory");
    m = log_c[4];
    entry(5, 2, 8'h03, "R6 mux restore");
    chk(log_c[5] == m + 377, "R5 poll sample timing", log_c[5] - m, 377);
    entry(6, 3, 8'h30, "R6 pll0 restore"); gap(6, 25, "R6 gap pll0");
    entry(7, 4, 8'h30, "R6 pll1 restore"); gap(7, 25, "R6 gap pll1");
    entry(8, 1, 8'h01, "R6 events set last");
    chk(rail_sel == 1'b1, "R9 rail after success", rail_sel, 1);
    chk(!timeout_err, "R9 no error on success", timeout_err, 0);
  endtask

  task automatic t_legacy_cluster;
    int m;
    start(1'b0, 32'h1001_0000, 8'h00, 8'hF3, 10);
    wait_idle();
    chk(log_n == 9, "R7 write count", log_n, 9);
    entry(4, 5, 8'h10, "R4 mode cluster");
    m = log_c[4];
    entry(5, 1, 8'h01, "R7 events set first");
    chk(log_c[5] == m + 127, "R5 masked status at second sample", log_c[5] - m, 127);
    entry(6, 2, 8'h03, "R7 mux restore");
    entry(7, 3, 8'h30, "R7 pll0 restore"); gap(7, 25, "R7 gap pll0");
    entry(8, 4, 8'h30, "R7 pll1 restore"); gap(8, 25, "R7 gap pll1");
    chk(rail_sel == 1'b0, "R9 rail back to cluster", rail_sel, 0);
  endtask

  task automatic t_timeout;
    int m;
    start(1'b1, 32'h1001_0000, 8'h03, 8'h03, -1);
    wait_idle();
    chk(log_n == 9, "R9 trailing steps after timeout", log_n, 9);
    m = log_c[4];
    entry(5, 2, 8'h03, "R9 restore after timeout");
    chk(log_c[5] == m + 1127, "R5 ten samples before timeout", log_c[5] - m, 1127);
    chk(timeout_err, "R9 timeout flagged", timeout_err, 1);
    chk(rail_sel == 1'b0, "R9 rail kept on timeout", rail_sel, 0);
  endtask

  task automatic t_new_rev;
    start(1'b1, 32'h1002_0000, 8'h00, 8'h00, -1);
    chk(!timeout_err, "R10 error cleared on accept", timeout_err, 0);
    wait_idle();
    chk(log_n == 1, "R8 only mode write", log_n, 1);
    entry(0, 5, 8'h00, "R8 mode write");
    chk(rail_sel == 1'b1, "R8 rail switched", rail_sel, 1);
  endtask

  task automatic t_rev_boundary;
    start(1'b0, 32'h1001_FFFF, 8'h03, 8'h03, -1);
    wait_idle();
    chk(log_n == 9, "R3 revision just below limit wraps", log_n, 9);
    entry(0, 1, 8'h00, "R3 boundary event clear");
    chk(rail_sel == 1'b0, "R9 rail cluster", rail_sel, 0);
  endtask

  task automatic t_ignore_busy;
    int modes = 0;
    start(1'b1, 32'h2000_0000, 8'h07, 8'h00, 200);
    repeat (50) @(negedge clk);
    req_rail = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    for (int i = 0; i < log_n; i++) if (log_k[i] == 5) modes++;
    chk(modes == 1, "R2 one mode write despite busy request", modes, 1);
    chk(rail_sel == 1'b1, "R2 running target kept", rail_sel, 1);
    repeat (5) @(negedge clk);
    chk(!busy, "R2 no restart after busy request", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy_mem();
    t_legacy_cluster();
    t_timeout();
    t_new_rev();
    t_rev_boundary();
    t_ignore_busy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule